// File: doc/BRIEF.md
# Composite Memory Select Combiner

This block produces one composite chip-select that follows any chosen set of four individual memory-space selects: program, data, byte and I/O. A board can then drive a single memory from several spaces through one select line. The selects are active-low by default. The composite output is a purely combinational function of the incoming selects and the stored enable bits. It therefore asserts in the same cycle as the select that causes it, with no register stage in the path.

The enables live in a 16-bit control register mapped at data address 0x3FE6. The same register also holds two other fields. One is a 3-bit wait field for the byte space. The other is eight direction bits for the programmable flag pins. The block sends the wait field and the direction bits out as plain outputs. A simple bus port reads and writes the register. A write lands on the next rising clock edge. A read is combinational. Bit 15 is reserved and always reads as zero.

Top module: `csel_combiner`

## Requirements
- R1: With the default active-low polarity, `comb_sel` is 0 in the same cycle that any input select whose enable bit is 1 is 0. Otherwise it is 1.
- R2: The enable bits are register bit 8 for `prog_sel`, bit 9 for `data_sel`, bit 10 for `byte_sel` and bit 11 for `io_sel`. A cleared enable bit keeps that select out of `comb_sel`.
- R3: After reset the register reads 0x7B00. The enables for program, data and I/O are 1 and the byte enable is 0. The byte wait field is 7 and all flag direction bits are 0.
- R4: `flag_dir[7:0]` equals register bits 7:0. A 1 marks an output and a 0 marks an input.
- R5: `bwait` equals register bits 14:12.
- R6: A cycle with `bus_en`=1, `bus_we`=1 and `bus_addr`=0x3FE6 loads `bus_wdata` at that rising edge. A write to any other address leaves the register unchanged.
- R7: While `bus_en`=1, `bus_we`=0 and `bus_addr`=0x3FE6, `bus_rdata` shows the register in the same cycle. In every other cycle it is 0.
- R8: Bit 15 is reserved. Writing a 1 into it has no effect, and it reads back as 0.
- R9: When `bus_en`=0, `bus_we`=1 changes nothing in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Data-space address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when the register is not being read |
| prog_sel | input | 1 | Program-space select |
| data_sel | input | 1 | Data-space select |
| byte_sel | input | 1 | Byte-space select |
| io_sel | input | 1 | I/O-space select |
| comb_sel | output | 1 | Composite select |
| flag_dir | output | 8 | Flag pin directions |
| bwait | output | 3 | Byte-space wait count |

## Verification
The assertions sample at rising edges. They assume the bus signals and the four selects are steady around each edge, and that the selects use the configured polarity. The bench respects this by changing every input only at the falling edge. It then checks the combinational outputs one nanosecond later. Random writes use arbitrary addresses and strobes. This lets the hold property see rejected writes as well as accepted ones.

// File: rtl/csel_pkg.sv
package csel_pkg;

   typedef enum int unsigned {
      SEL_PROG = 0,
      SEL_DATA = 1,
      SEL_BYTE = 2,
      SEL_IO   = 3
   } sel_idx_e;

   localparam int unsigned NUM_SPACES = 4;

   // contiguous field mask of 'width' bits starting at 'lsb'
   function automatic logic [63:0] field_mask(input int unsigned lsb,
                                              input int unsigned width);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < width; i++) begin
         m[lsb + i] = 1'b1;
      end
      return m;
   endfunction

   // place 'val' into a 64-bit word at 'lsb'
   function automatic logic [63:0] field_place(input logic [63:0] val,
                                               input int unsigned lsb,
                                               input int unsigned width);
      return (val & field_mask(0, width)) << lsb;
   endfunction

endpackage

// File: rtl/csel_bus_port.sv
module csel_bus_port #(
   parameter int unsigned      ADDR_W   = 14,
   parameter int unsigned      DATA_W   = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = 14'h3FE6
) (
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] reg_q,
   output logic              wr_stb,
   output logic [DATA_W-1:0] bus_rdata
);

   logic addr_hit;
   logic rd_stb;

   assign addr_hit = bus_en && (bus_addr == REG_ADDR);
   assign wr_stb   = addr_hit &&  bus_we;
   assign rd_stb   = addr_hit && !bus_we;

   always_comb begin
      bus_rdata = '0;
      if (rd_stb) begin
         bus_rdata = reg_q;
      end
   end

endmodule

// File: rtl/csel_ctrl_reg.sv
module csel_ctrl_reg #(
   parameter int unsigned      DATA_W  = 16,
   parameter logic [DATA_W-1:0] RW_MASK = 16'h7FFF,
   parameter logic [DATA_W-1:0] RST_VAL = 16'h7B00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   localparam logic [DATA_W-1:0] RST_MASKED = RST_VAL & RW_MASK;

   logic [DATA_W-1:0] wr_val;

   // reserved positions are forced to zero before storage
   assign wr_val = wdata & RW_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_MASKED;
      end else if (wr_stb) begin
         q <= wr_val;
      end
   end

endmodule

// File: rtl/csel_combine.sv
module csel_combine #(
   parameter int unsigned NUM_SEL    = 4,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic [NUM_SEL-1:0] sel_in,
   input  logic [NUM_SEL-1:0] enable,
   output logic               comb_out
);

   logic [NUM_SEL-1:0] active;
   logic [NUM_SEL-1:0] gated;
   logic               any_hit;

   generate
      if (ACTIVE_LOW) begin : g_pol_low
         assign active   = ~sel_in;
         assign comb_out = ~any_hit;
      end else begin : g_pol_high
         assign active   = sel_in;
         assign comb_out = any_hit;
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_gate
         assign gated[i] = active[i] & enable[i];
      end
   endgenerate

   assign any_hit = |gated;

endmodule

// File: rtl/csel_combiner.sv
module csel_combiner #(
   parameter int unsigned       ADDR_W     = 14,
   parameter int unsigned       DATA_W     = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 14'h3FE6,
   parameter int unsigned       FLAG_N     = 8,
   parameter int unsigned       FLAG_LSB   = 0,
   parameter int unsigned       EN_LSB     = 8,
   parameter int unsigned       WAIT_W     = 3,
   parameter int unsigned       WAIT_LSB   = 12,
   parameter logic [3:0]        RST_EN     = 4'b1011,
   parameter logic [2:0]        RST_WAIT   = 3'd7,
   parameter bit                ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              prog_sel,
   input  logic              data_sel,
   input  logic              byte_sel,
   input  logic              io_sel,
   output logic              comb_sel,
   output logic [FLAG_N-1:0] flag_dir,
   output logic [WAIT_W-1:0] bwait
);

   import csel_pkg::*;

   localparam int unsigned NUM_SEL = NUM_SPACES;

   localparam logic [63:0] FLAG_M64 = field_mask(FLAG_LSB, FLAG_N);
   localparam logic [63:0] EN_M64   = field_mask(EN_LSB,   NUM_SEL);
   localparam logic [63:0] WAIT_M64 = field_mask(WAIT_LSB, WAIT_W);

   localparam logic [DATA_W-1:0] RW_MASK = DATA_W'(FLAG_M64 | EN_M64 | WAIT_M64);
   localparam logic [DATA_W-1:0] RST_VAL =
      DATA_W'(field_place(64'(RST_EN),   EN_LSB,   NUM_SEL) |
              field_place(64'(RST_WAIT), WAIT_LSB, WAIT_W));

   // elaboration-time parameter checks
   generate
      if (FLAG_LSB + FLAG_N > DATA_W) begin : g_err_flag
         $error("flag field exceeds register width");
      end
      if (EN_LSB + NUM_SEL > DATA_W) begin : g_err_en
         $error("enable field exceeds register width");
      end
      if (WAIT_LSB + WAIT_W > DATA_W) begin : g_err_wait
         $error("wait field exceeds register width");
      end
      if (((FLAG_M64 & EN_M64) | (FLAG_M64 & WAIT_M64) | (EN_M64 & WAIT_M64)) != 64'd0) begin : g_err_ovl
         $error("register fields overlap");
      end
      if (DATA_W > 64) begin : g_err_dw
         $error("register width above 64 bits");
      end
   endgenerate

   logic [DATA_W-1:0]  reg_q;
   logic               wr_stb;
   logic [NUM_SEL-1:0] sel_vec;
   logic [NUM_SEL-1:0] en_vec;

   assign sel_vec[int'(SEL_PROG)] = prog_sel;
   assign sel_vec[int'(SEL_DATA)] = data_sel;
   assign sel_vec[int'(SEL_BYTE)] = byte_sel;
   assign sel_vec[int'(SEL_IO)]   = io_sel;

   csel_bus_port #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR)
   ) u_bus (
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .reg_q     (reg_q),
      .wr_stb    (wr_stb),
      .bus_rdata (bus_rdata)
   );

   csel_ctrl_reg #(
      .DATA_W  (DATA_W),
      .RW_MASK (RW_MASK),
      .RST_VAL (RST_VAL)
   ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .wdata  (bus_wdata),
      .q      (reg_q)
   );

   assign en_vec   = reg_q[EN_LSB   +: NUM_SEL];
   assign flag_dir = reg_q[FLAG_LSB +: FLAG_N];
   assign bwait    = reg_q[WAIT_LSB +: WAIT_W];

   csel_combine #(
      .NUM_SEL    (NUM_SEL),
      .ACTIVE_LOW (ACTIVE_LOW)
   ) u_comb (
      .sel_in   (sel_vec),
      .enable   (en_vec),
      .comb_out (comb_sel)
   );

endmodule

// File: rtl/csel_combiner_chk.sv
module csel_combiner_chk #(
   parameter int unsigned       ADDR_W     = 14,
   parameter int unsigned       DATA_W     = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 14'h3FE6,
   parameter int unsigned       FLAG_N     = 8,
   parameter int unsigned       WAIT_W     = 3,
   parameter int unsigned       FLAG_LSB   = 0,
   parameter int unsigned       WAIT_LSB   = 12,
   parameter logic [DATA_W-1:0] RW_MASK    = 16'h7FFF,
   parameter bit                ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              prog_sel,
   input logic              data_sel,
   input logic              byte_sel,
   input logic              io_sel,
   input logic              comb_sel,
   input logic [FLAG_N-1:0] flag_dir,
   input logic [WAIT_W-1:0] bwait
);

   localparam logic IDLE = ACTIVE_LOW ? 1'b1 : 1'b0;

   logic all_idle;
   logic do_wr;
   logic do_rd;

   assign all_idle = (prog_sel == IDLE) && (data_sel == IDLE) &&
                     (byte_sel == IDLE) && (io_sel == IDLE);
   assign do_wr = bus_en && bus_we && (bus_addr == REG_ADDR);
   assign do_rd = bus_en && !bus_we && (bus_addr == REG_ADDR);

   AST_IDLE_NO_COMB: assert property (@(posedge clk) disable iff (!rst_n)
      all_idle |-> (comb_sel == IDLE)); // R1

   AST_COMB_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (comb_sel != IDLE) |-> !all_idle); // R2

   AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      do_wr |=> (flag_dir == $past(bus_wdata[FLAG_LSB +: FLAG_N]))); // R4

   AST_WRITE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      do_wr |=> (bwait == $past(bus_wdata[WAIT_LSB +: WAIT_W]))); // R5

   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !do_wr |=> ($stable(flag_dir) && $stable(bwait))); // R6

   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !do_rd |-> (bus_rdata == '0)); // R7

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      do_rd |-> ((bus_rdata & ~RW_MASK) == '0)); // R8

endmodule

bind csel_combiner csel_combiner_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .REG_ADDR   (REG_ADDR),
   .FLAG_N     (FLAG_N),
   .WAIT_W     (WAIT_W),
   .FLAG_LSB   (FLAG_LSB),
   .WAIT_LSB   (WAIT_LSB),
   .RW_MASK    (RW_MASK),
   .ACTIVE_LOW (ACTIVE_LOW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .prog_sel  (prog_sel),
   .data_sel  (data_sel),
   .byte_sel  (byte_sel),
   .io_sel    (io_sel),
   .comb_sel  (comb_sel),
   .flag_dir  (flag_dir),
   .bwait     (bwait)
);

// File: tb/csel_combiner_bench.sv
`timescale 1ns/1ps
module csel_combiner_bench;

   localparam logic [13:0] REG_A = 14'h3FE6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [13:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        prog_sel = 1'b1;
   logic        data_sel = 1'b1;
   logic        byte_sel = 1'b1;
   logic        io_sel = 1'b1;
   logic        comb_sel;
   logic [7:0]  flag_dir;
   logic [2:0]  bwait;

   int unsigned n_chk  = 0;
   int unsigned n_fail = 0;
   int unsigned cycles = 0;
   logic [15:0] exp_reg = 16'h7B00;

   csel_combiner u_csel_combiner (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .prog_sel  (prog_sel),
      .data_sel  (data_sel),
      .byte_sel  (byte_sel),
      .io_sel    (io_sel),
      .comb_sel  (comb_sel),
      .flag_dir  (flag_dir),
      .bwait     (bwait)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // sels bit order: [0] prog, [1] data, [2] byte, [3] io (0 = asserted)
   function automatic logic exp_comb(input logic [15:0] r, input logic [3:0] s);
      logic hit;
      hit = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (r[8 + i] && !s[i]) hit = 1'b1;
      end
      return !hit;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_sels(input logic [3:0] s);
      prog_sel = s[0];
      data_sel = s[1];
      byte_sel = s[2];
      io_sel   = s[3];
   endtask

   task automatic chk_comb(input string req, input logic [3:0] s);
      @(negedge clk);
      set_sels(s);
      #1;
      chk(req, {15'd0, comb_sel}, {15'd0, exp_comb(exp_reg, s)});
   endtask

   task automatic reg_write(input logic [13:0] a, input logic [15:0] d, input logic en);
      @(negedge clk);
      bus_en = en;
      bus_we = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0;
      bus_we = 1'b0;
      if (en && a == REG_A) exp_reg = d & 16'h7FFF;
   endtask

   task automatic reg_read(input string req, input logic [13:0] a);
      @(negedge clk);
      bus_en = 1'b1;
      bus_we = 1'b0;
      bus_addr = a;
      #1;
      chk(req, bus_rdata, (a == REG_A) ? exp_reg : 16'h0000);
      bus_en = 1'b0;
   endtask

   task automatic chk_fields();
      #1;
      chk("R4 flag_dir", {8'd0, flag_dir}, {8'd0, exp_reg[7:0]});
      chk("R5 bwait", {13'd0, bwait}, {13'd0, exp_reg[14:12]});
   endtask

   initial begin
      void'($urandom(32'h1D5E_ED01));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 reset contents
      reg_read("R3 reset readback", REG_A);
      chk("R3 reset flag_dir", {8'd0, flag_dir}, 16'h0000);
      chk("R3 reset bwait", {13'd0, bwait}, 16'h0007);
      chk_comb("R3 byte disabled at reset", 4'b1011);
      chk_comb("R3 prog enabled at reset", 4'b1110);
      chk_comb("R3 io enabled at reset", 4'b0111);

      // R7 no read strobe -> zero
      @(negedge clk);
      bus_addr = REG_A; bus_en = 1'b0; bus_we = 1'b0;
      #1 chk("R7 idle rdata", bus_rdata, 16'h0000);
      reg_read("R7 other address read", 14'h3FE5);

      // R1 R2 sweep: every enable set against every select pattern
      for (int e = 0; e < 16; e++) begin
         logic [15:0] w;
         w = {1'b0, 3'($urandom), 4'(e), 8'($urandom)};
         reg_write(REG_A, w, 1'b1);
         reg_read("R6 write lands", REG_A);
         chk_fields();
         for (int p = 0; p < 16; p++) begin
            chk_comb("R1 R2 comb sweep", 4'(p));
         end
      end

      // R8 reserved bit
      reg_write(REG_A, 16'hFFFF, 1'b1);
      reg_read("R8 reserved reads zero", REG_A);
      chk_fields();

      // R6 wrong address ignored
      reg_write(REG_A, 16'h1234, 1'b1);
      reg_write(14'h3FE7, 16'h0000, 1'b1);
      reg_read("R6 other address write ignored", REG_A);
      chk_fields();

      // R9 strobe low ignored
      reg_write(REG_A, 16'h0000, 1'b0);
      reg_read("R9 write without bus_en ignored", REG_A);
      chk_fields();

      // random mix
      for (int k = 0; k < 600; k++) begin
         int unsigned op;
         op = $urandom_range(0, 3);
         case (op)
            0: reg_write(($urandom_range(0, 1) == 0) ? REG_A : 14'($urandom),
                         16'($urandom), 1'($urandom));
            1: reg_read("R7 random read", ($urandom_range(0, 2) == 0) ? 14'($urandom) : REG_A);
            default: chk_comb("R1 random comb", 4'($urandom));
         endcase
         if (op == 0) chk_fields();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule